// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of a ring of counter groups, three counter channels per group. For every channel it holds a 3-bit clock-source code and a 3-bit gate-source code, written and read back through a small configuration port. From those codes it produces, in the system clock domain, a one-cycle clock-enable pulse and a gate level for each channel. It also produces output-enable controls for the channel's clock and gate pins, which become outputs whenever the pin is not the selected source.

Clock sources are the channel's own clock pin, five decade rates made by a shared prescaler from a base tick, the output of the preceding channel, and an external clock shared by the three channels of a group. Gate sources are fixed on, fixed off, the channel's own gate pin, or the inverted output of the channel two places back. The chained links wrap across groups as a ring, so the last group precedes group 0. The readback port also returns the period, in nanoseconds, of the internal rate that the addressed channel uses.

Top module: `ctr_route`

## Requirements
- R1: Both codes of every channel reset to 0. A write with `cfg_we_i` high stores `cfg_wdata_i` into the clock code (`cfg_wsel_i`=0) or the gate code (`cfg_wsel_i`=1) of channel `cfg_wch_i`. `cfg_rdata_o` shows the code selected by `cfg_rch_i` and `cfg_rsel_i` one clock later. It reads 0 for a channel index at or above the channel count.
- R2: Clock code 0 gives one `clk_en_o` pulse per rising edge on the channel's own `clk_pin_i`, after a two-flop synchronizer.
- R3: Clock codes 1..5 give single-cycle pulses at base-tick rate divided by 1, 10, 100, 1000 and 10000. No pulses occur while `base_tick_i` is low.
- R4: Clock code 6 pulses once per rising edge of `ctr_out_i` of channel n-1 in the same group. For channel 0 the source is channel 2 of the preceding group in the ring.
- R5: Clock code 7 pulses once per rising edge of the group's shared `grp_clk_i`, and all three channels of that group follow it.
- R6: `clk_pin_oe_o` of a channel is high exactly when its clock code is not 0.
- R7: Gate code 0 drives `gate_o` high and gate code 1 drives it low.
- R8: Gate code 2 passes the synchronized level of the channel's own `gat_pin_i`. `gat_pin_oe_o` is high exactly when the gate code is not 2.
- R9: Gate code 3 gives the inverted `ctr_out_i` of channel 0 of the same group for channel 2. For channels 0 and 1 it gives that of channel n+1 of the preceding group in the ring.
- R10: Gate codes 4..7 drive `gate_o` low.
- R11: `period_ns_o` one clock after a read shows 100, 1000, 10000, 100000 or 1000000 for clock codes 1..5 of the addressed channel, and 0 for any other code.
- R12: For clock codes 2..5 the enable is never high on two consecutive cycles while the code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick_i | input | 1 | Base-rate enable (10 MHz ticks) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wsel_i | input | 1 | Write target: 0 clock code, 1 gate code |
| cfg_wch_i | input | CH_W | Channel index for writes |
| cfg_wdata_i | input | 3 | Code to write |
| cfg_rch_i | input | CH_W | Channel index for reads |
| cfg_rsel_i | input | 1 | Read target: 0 clock code, 1 gate code |
| cfg_rdata_o | output | 3 | Registered code readback |
| period_ns_o | output | PER_W | Registered period of the addressed channel's internal rate |
| clk_pin_i | input | NCH | Per-channel external clock pins |
| gat_pin_i | input | NCH | Per-channel external gate pins |
| grp_clk_i | input | N_GROUPS | Shared external clock per group |
| ctr_out_i | input | NCH | Counter outputs, one per channel |
| clk_en_o | output | NCH | Per-channel count-enable pulses |
| gate_o | output | NCH | Per-channel gate levels |
| clk_pin_oe_o | output | NCH | Clock pin drives outward when high |
| gat_pin_oe_o | output | NCH | Gate pin drives outward when high |

## Verification
The bench keeps the default two groups, six channels, so both ring wrap links (channel 0 clock and channels 0 and 1 gate reaching into the other group) and the group-shared clock are all in play. It sweeps every channel through all eight gate codes and every clock code, one-hot stimulating each possible source to confirm that only the mapped one acts. With a decade of 10 the slow rates take up to 10000 cycles per period, so the two slowest rates are counted on one channel per group only, over exactly two periods each.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

  localparam int CODE_W = 3;
  localparam int CH_PER_GRP = 3;

  localparam logic [CODE_W-1:0] CK_PIN   = 3'd0;
  localparam logic [CODE_W-1:0] CK_CHAIN = 3'd6;
  localparam logic [CODE_W-1:0] CK_GROUP = 3'd7;

  localparam logic [CODE_W-1:0] GT_ON  = 3'd0;
  localparam logic [CODE_W-1:0] GT_OFF = 3'd1;
  localparam logic [CODE_W-1:0] GT_PIN = 3'd2;
  localparam logic [CODE_W-1:0] GT_INV = 3'd3;

  // Channel whose output feeds the chained clock of channel ch.
  function automatic int chain_clk_src(int ch, int ngrp);
    int g, n, pg;
    g  = ch / CH_PER_GRP;
    n  = ch % CH_PER_GRP;
    pg = (g + ngrp - 1) % ngrp;
    return (n > 0) ? ch - 1 : pg * CH_PER_GRP + 2;
  endfunction

  // Channel whose inverted output feeds the gate of channel ch.
  function automatic int chain_gate_src(int ch, int ngrp);
    int g, n, pg;
    g  = ch / CH_PER_GRP;
    n  = ch % CH_PER_GRP;
    pg = (g + ngrp - 1) % ngrp;
    return (n == 2) ? g * CH_PER_GRP : pg * CH_PER_GRP + n + 1;
  endfunction

  // Period in ns of the internal rate selected by a clock code.
  function automatic logic [31:0] rate_period(logic [CODE_W-1:0] code,
                                              int base_ns, int dec, int nrates);
    logic [31:0] p;
    if (code == 3'd0 || int'(code) > nrates) return 32'd0;
    p = 32'(base_ns);
    for (int k = 2; k < 8; k++)
      if (k <= int'(code)) p = p * 32'(dec);
    return p;
  endfunction

endpackage

// File: rtl/ctr_prescale.sv
module ctr_prescale #(
  parameter int DECADE  = 10,
  parameter int N_RATES = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               base_i,
  output logic [N_RATES-1:0] tick_o
);
  localparam int CW = $clog2(DECADE);

  assign tick_o[0] = base_i;

  for (genvar k = 1; k < N_RATES; k++) begin : g_stage
    logic [CW-1:0] cnt_q;
    logic          wrap;
    assign wrap      = (cnt_q == CW'(DECADE - 1));
    assign tick_o[k] = tick_o[k-1] & wrap;
    always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (tick_o[k-1]) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctr_sync_edge.sv
module ctr_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/ctr_chan_sel.sv
module ctr_chan_sel
  import ctr_route_pkg::*;
#(
  parameter int N_RATES = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  ccode_i,
  input  logic [CODE_W-1:0]  gcode_i,
  input  logic [N_RATES-1:0] tick_i,
  input  logic               pin_rise_i,
  input  logic               grp_rise_i,
  input  logic               chain_rise_i,
  input  logic               gpin_lvl_i,
  input  logic               inv_src_i,
  output logic               clk_en_o,
  output logic               gate_o,
  output logic               clk_oe_o,
  output logic               gat_oe_o
);
  logic en_d, gate_d;

  always_comb begin
    en_d = 1'b0;
    case (ccode_i)
      CK_PIN:   en_d = pin_rise_i;
      CK_CHAIN: en_d = chain_rise_i;
      CK_GROUP: en_d = grp_rise_i;
      default: begin
        for (int k = 0; k < N_RATES; k++)
          if (ccode_i == CODE_W'(k + 1)) en_d = tick_i[k];
      end
    endcase
  end

  always_comb begin
    case (gcode_i)
      GT_ON:   gate_d = 1'b1;
      GT_OFF:  gate_d = 1'b0;
      GT_PIN:  gate_d = gpin_lvl_i;
      GT_INV:  gate_d = ~inv_src_i;
      default: gate_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_o <= 1'b0;
      gate_o   <= 1'b0;
      clk_oe_o <= 1'b0;
      gat_oe_o <= 1'b0;
    end else begin
      clk_en_o <= en_d;
      gate_o   <= gate_d;
      clk_oe_o <= (ccode_i != CK_PIN);
      gat_oe_o <= (gcode_i != GT_PIN);
    end
  end
endmodule

// File: rtl/ctr_route.sv
module ctr_route
  import ctr_route_pkg::*;
#(
  parameter int N_GROUPS = 2,
  parameter int DECADE   = 10,
  parameter int N_RATES  = 5,
  parameter int BASE_NS  = 100,
  parameter int PER_W    = 20,
  parameter int NCH      = N_GROUPS * CH_PER_GRP,
  parameter int CH_W     = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  base_tick_i,
  input  logic                  cfg_we_i,
  input  logic                  cfg_wsel_i,
  input  logic [CH_W-1:0]       cfg_wch_i,
  input  logic [CODE_W-1:0]     cfg_wdata_i,
  input  logic [CH_W-1:0]       cfg_rch_i,
  input  logic                  cfg_rsel_i,
  output logic [CODE_W-1:0]     cfg_rdata_o,
  output logic [PER_W-1:0]      period_ns_o,
  input  logic [NCH-1:0]        clk_pin_i,
  input  logic [NCH-1:0]        gat_pin_i,
  input  logic [N_GROUPS-1:0]   grp_clk_i,
  input  logic [NCH-1:0]        ctr_out_i,
  output logic [NCH-1:0]        clk_en_o,
  output logic [NCH-1:0]        gate_o,
  output logic [NCH-1:0]        clk_pin_oe_o,
  output logic [NCH-1:0]        gat_pin_oe_o
);
  logic [CODE_W-1:0]   ccode_q [NCH];
  logic [CODE_W-1:0]   gcode_q [NCH];
  logic [N_RATES-1:0]  tick;
  logic [NCH-1:0]      cpin_lvl, cpin_rise, gpin_lvl, gpin_rise;
  logic [N_GROUPS-1:0] grp_lvl, grp_rise;
  logic [NCH-1:0]      out_q, out_rise;

  // Configuration store
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        ccode_q[i] <= '0;
        gcode_q[i] <= '0;
      end
    end else if (cfg_we_i && int'(cfg_wch_i) < NCH) begin
      if (cfg_wsel_i) gcode_q[cfg_wch_i] <= cfg_wdata_i;
      else            ccode_q[cfg_wch_i] <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata_o <= '0;
      period_ns_o <= '0;
    end else if (int'(cfg_rch_i) < NCH) begin
      cfg_rdata_o <= cfg_rsel_i ? gcode_q[cfg_rch_i] : ccode_q[cfg_rch_i];
      period_ns_o <= PER_W'(rate_period(ccode_q[cfg_rch_i], BASE_NS, DECADE, N_RATES));
    end else begin
      cfg_rdata_o <= '0;
      period_ns_o <= '0;
    end
  end

  ctr_prescale #(.DECADE(DECADE), .N_RATES(N_RATES)) u_pre (
    .clk(clk), .rst(rst), .base_i(base_tick_i), .tick_o(tick)
  );

  ctr_sync_edge #(.W(NCH)) u_csync (
    .clk(clk), .rst(rst), .d_i(clk_pin_i), .lvl_o(cpin_lvl), .rise_o(cpin_rise)
  );
  ctr_sync_edge #(.W(NCH)) u_gsync (
    .clk(clk), .rst(rst), .d_i(gat_pin_i), .lvl_o(gpin_lvl), .rise_o(gpin_rise)
  );
  ctr_sync_edge #(.W(N_GROUPS)) u_xsync (
    .clk(clk), .rst(rst), .d_i(grp_clk_i), .lvl_o(grp_lvl), .rise_o(grp_rise)
  );

  // Counter outputs are already in this clock domain: edge detect only.
  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= ctr_out_i;
  end
  assign out_rise = ctr_out_i & ~out_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int GRP  = i / CH_PER_GRP;
    localparam int CSRC = chain_clk_src(i, N_GROUPS);
    localparam int GSRC = chain_gate_src(i, N_GROUPS);

    ctr_chan_sel #(.N_RATES(N_RATES)) u_sel (
      .clk         (clk),
      .rst         (rst),
      .ccode_i     (ccode_q[i]),
      .gcode_i     (gcode_q[i]),
      .tick_i      (tick),
      .pin_rise_i  (cpin_rise[i]),
      .grp_rise_i  (grp_rise[GRP]),
      .chain_rise_i(out_rise[CSRC]),
      .gpin_lvl_i  (gpin_lvl[i]),
      .inv_src_i   (ctr_out_i[GSRC]),
      .clk_en_o    (clk_en_o[i]),
      .gate_o      (gate_o[i]),
      .clk_oe_o    (clk_pin_oe_o[i]),
      .gat_oe_o    (gat_pin_oe_o[i])
    );
  end

  // Levels of clock pins, group clocks and gate-pin edges are not used.
  logic unused_ok;
  assign unused_ok = ^{cpin_lvl, gpin_rise, grp_lvl};
endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     ccode [NCH],
  input logic [2:0]     gcode [NCH],
  input logic [NCH-1:0] clk_en,
  input logic [NCH-1:0] gate,
  input logic [NCH-1:0] clk_oe,
  input logic [NCH-1:0] gat_oe
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r6_clk_dir_out: assert property (@(posedge clk) disable iff (rst)
      (ccode[i] != 3'd0) |=> clk_oe[i]);
    a_r6_clk_dir_in: assert property (@(posedge clk) disable iff (rst)
      (ccode[i] == 3'd0) |=> !clk_oe[i]);
    a_r8_gat_dir: assert property (@(posedge clk) disable iff (rst)
      (gcode[i] == 3'd2) |=> !gat_oe[i]);
    a_r7_gate_on: assert property (@(posedge clk) disable iff (rst)
      (gcode[i] == 3'd0) |=> gate[i]);
    a_r7_gate_off: assert property (@(posedge clk) disable iff (rst)
      (gcode[i] == 3'd1) |=> !gate[i]);
    a_r10_reserved_low: assert property (@(posedge clk) disable iff (rst)
      (gcode[i] >= 3'd4) |=> !gate[i]);
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (clk_en[i] && $past(ccode[i]) >= 3'd2 && $past(ccode[i]) <= 3'd5
       && ccode[i] == $past(ccode[i])) |=> !clk_en[i]);
  end
endmodule

bind ctr_route ctr_route_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ccode(ccode_q), .gcode(gcode_q),
  .clk_en(clk_en_o), .gate(gate_o), .clk_oe(clk_pin_oe_o), .gat_oe(gat_pin_oe_o)
);

// File: tb/sim_ctr_route.sv
module sim_ctr_route;
  localparam int NG = 2;
  localparam int NCH = 6;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base = 1'b1;
  logic we = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [CW-1:0] wch = '0, rch = '0;
  logic [2:0] wdata = '0;
  logic [2:0] rdata;
  logic [19:0] period;
  logic [NCH-1:0] cpin = '0, gpin = '0, cout = '0;
  logic [NG-1:0] gclk = '0;
  logic [NCH-1:0] clk_en, gate, coe, goe;

  int total = 0, bad = 0;
  int pc [NCH];

  always #2 clk = ~clk;

  ctr_route u0 (
    .clk(clk), .rst(rst), .base_tick_i(base),
    .cfg_we_i(we), .cfg_wsel_i(wsel), .cfg_wch_i(wch), .cfg_wdata_i(wdata),
    .cfg_rch_i(rch), .cfg_rsel_i(rsel), .cfg_rdata_o(rdata), .period_ns_o(period),
    .clk_pin_i(cpin), .gat_pin_i(gpin), .grp_clk_i(gclk), .ctr_out_i(cout),
    .clk_en_o(clk_en), .gate_o(gate), .clk_pin_oe_o(coe), .gat_pin_oe_o(goe)
  );

  initial for (int i = 0; i < NCH; i++) pc[i] = 0;
  always @(negedge clk) for (int i = 0; i < NCH; i++) pc[i] += int'(clk_en[i]);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wcfg(int ch, bit sel, int val);
    @(negedge clk);
    we = 1'b1; wsel = sel; wch = CW'(ch); wdata = 3'(val);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int ch, bit sel);
    @(negedge clk);
    rch = CW'(ch); rsel = sel;
    @(negedge clk);
  endtask

  function automatic int clk_src(int i);
    return (i + NCH - 1) % NCH;
  endfunction

  function automatic int gate_src(int i);
    int g = i / 3, n = i % 3;
    return (n == 2) ? g * 3 : ((g + NG - 1) % NG) * 3 + n + 1;
  endfunction

  function automatic int pow10(int e);
    int p = 1;
    for (int k = 0; k < e; k++) p *= 10;
    return p;
  endfunction

  // Counts enables on channel ch over a window: returns delta.
  task automatic count_win(int ch, int cyc, output int n);
    int a;
    @(posedge clk); a = pc[ch];
    repeat (cyc) @(posedge clk);
    n = pc[ch] - a;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, a, ev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 reset clk_en", int'(clk_en), 0);
    chk("R7 reset gate code0 on", int'(gate), 63);
    chk("R6 reset clk oe", int'(coe), 0);
    chk("R8 reset gat oe", int'(goe), 63);
    for (int i = 0; i < NCH; i++) begin
      rd(i, 0); chk("R1 reset ccode", int'(rdata), 0);
      rd(i, 1); chk("R1 reset gcode", int'(rdata), 0);
    end

    // R1 write/readback
    for (int i = 0; i < NCH; i++) begin
      wcfg(i, 0, (i + 1) % 8);
      wcfg(i, 1, 7 - i);
    end
    for (int i = 0; i < NCH; i++) begin
      rd(i, 0); chk("R1 ccode readback", int'(rdata), (i + 1) % 8);
      rd(i, 1); chk("R1 gcode readback", int'(rdata), 7 - i);
    end
    rd(7, 0); chk("R1 out of range read", int'(rdata), 0);

    // R11 period readback
    for (int c = 0; c < 8; c++) begin
      wcfg(2, 0, c);
      rd(2, 0);
      ev = (c >= 1 && c <= 5) ? 100 * pow10(c - 1) : 0;
      chk("R11 period", int'(period), ev);
    end

    // Gate sweep: R7 R8 R9 R10
    for (int i = 0; i < NCH; i++) begin
      for (int gc = 0; gc < 8; gc++) begin
        wcfg(i, 1, gc);
        repeat (2) @(negedge clk);
        chk("R8 gat oe", int'(goe[i]), (gc != 2) ? 1 : 0);
        for (int j = 0; j < NCH; j++) begin
          @(negedge clk);
          cout = NCH'(1) << j;
          gpin = NCH'(1) << j;
          repeat (4) @(negedge clk);
          case (gc)
            0: ev = 1;
            1: ev = 0;
            2: ev = (j == i) ? 1 : 0;
            3: ev = (j == gate_src(i)) ? 0 : 1;
            default: ev = 0;
          endcase
          if (gc == 3)      chk("R9 inverted ring gate", int'(gate[i]), ev);
          else if (gc == 2) chk("R8 gate pin level", int'(gate[i]), ev);
          else if (gc < 2)  chk("R7 fixed gate", int'(gate[i]), ev);
          else              chk("R10 reserved gate", int'(gate[i]), ev);
        end
        @(negedge clk); cout = '0; gpin = '0;
      end
    end

    // Clock sweep: R2..R6
    for (int i = 0; i < NCH; i++) begin
      for (int cc = 0; cc < 8; cc++) begin
        if ((cc == 4 || cc == 5) && (i % 3) != 0) continue;
        wcfg(i, 0, cc);
        repeat (4) @(negedge clk);
        chk("R6 clk oe", int'(coe[i]), (cc != 0) ? 1 : 0);
        if (cc >= 1 && cc <= 5) begin
          count_win(i, 2 * pow10(cc - 1), n);
          chk("R3 decade rate pulses", n, 2);
        end else if (cc == 0 || cc == 6) begin
          for (int j = 0; j < NCH; j++) begin
            @(posedge clk); a = pc[i];
            for (int t = 0; t < 2; t++) begin
              @(negedge clk);
              if (cc == 0) cpin[j] = 1'b1; else cout[j] = 1'b1;
              repeat (3) @(negedge clk);
              cpin = '0; cout = '0;
              repeat (3) @(negedge clk);
            end
            repeat (6) @(posedge clk);
            n = pc[i] - a;
            if (cc == 0) chk("R2 own pin clock", n, (j == i) ? 2 : 0);
            else         chk("R4 ring chained clock", n, (j == clk_src(i)) ? 2 : 0);
          end
        end else begin
          for (int g = 0; g < NG; g++) begin
            @(posedge clk); a = pc[i];
            for (int t = 0; t < 2; t++) begin
              @(negedge clk); gclk[g] = 1'b1;
              repeat (3) @(negedge clk); gclk = '0;
              repeat (3) @(negedge clk);
            end
            repeat (6) @(posedge clk);
            chk("R5 group clock", pc[i] - a, (g == i / 3) ? 2 : 0);
          end
        end
      end
    end

    // R3 no pulses without base tick
    wcfg(0, 0, 1);
    @(negedge clk); base = 1'b0;
    repeat (3) @(negedge clk);
    count_win(0, 50, n);
    chk("R3 base low no pulses", n, 0);
    base = 1'b1;
    count_win(0, 20, n);
    chk("R3 base rate pulses", n, 20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule